// File: doc/BRIEF.md
# Watchdog and Reset-Delay Controller

This block runs entirely from a dedicated low-speed oscillator clock. It combines two timers. The first is a single reset-delay one-shot, which holds the processor core in reset for a fixed number of oscillator cycles. The second is a retriggerable watchdog counter. Any of five events fires the one-shot:
- power returning to good;
- a recovery from stop mode;
- a watchdog expiry while the CPU is running;
- a watchdog expiry while the CPU is halted;
- a watchdog expiry while the CPU is stopped.

The block records which event caused the latest reset. It also tells the port-mode registers whether to return to their defaults.

The watchdog is off until software first kicks it, and every later kick restarts its count. While the CPU is stopped the watchdog is frozen, and while halted it counts only if a halt-permission strobe has been given. A permanent-watchdog strobe changes all of this. Once given, the watchdog is armed without a kick, counts in every CPU mode, and stays armed through every internal reset. Only the external asynchronous reset clears it.

The power-good input and both wake inputs are asynchronous. Each passes through a two-flop synchronizer before its rising edge is detected.

Top module: `wdt_rst_ctrl`

## Requirements
- R1: A rising edge on `pwr_good` raises `core_rst` on the third oscillator edge after the input changes (two synchronizer flops plus the trigger register), and sets `rst_cause` to 3'd0.
- R2: Each trigger holds `core_rst` high for exactly `DLY` oscillator cycles. While `rst_n` is low, `core_rst`=1, `rst_cause`=3'd0 and `port_dflt`=1.
- R3: A new trigger while `core_rst` is high restarts the delay from zero. `core_rst` then stays high until `DLY` cycles after the last trigger.
- R4: A rising edge on `wake_pin` or `wake_alt` is a stop recovery only while `cpu_mode`=2'd2 (STOP). It sets `rst_cause` to 3'd1. In RUN (2'd0) or HALT (2'd1) the same edge has no effect.
- R5: While `core_rst` is high, `port_dflt` is high unless the latest trigger was a stop recovery from `wake_pin`.
- R6: Unless the permanent option is set, the watchdog stays disabled after any reset until the first `wdt_kick`, and it never expires while disabled.
- R7: An enabled watchdog in RUN expires after `TMO` counting cycles with no kick. It then triggers a reset with `rst_cause`=3'd2. Each kick restarts the count from zero.
- R8: Unless the permanent option is set, the watchdog does not count in STOP. It counts in HALT only after `wdt_halt_en` has been pulsed, and an expiry there gives `rst_cause`=3'd3. Any reset clears both the enable and the halt permission.
- R9: After `wdt_perm_set` is pulsed, the watchdog counts without a kick in every mode, and an expiry in STOP gives `rst_cause`=3'd4. Internal resets do not clear the option.
- R10: The watchdog count is held at zero while `core_rst` is high. Kicks that arrive while `core_rst` is high are ignored and do not enable the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Dedicated low-speed oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | Asynchronous supply-good status |
| wake_pin | input | 1 | Asynchronous wake request from the designated port pin |
| wake_alt | input | 1 | Asynchronous wake request from any other source |
| cpu_mode | input | 2 | CPU mode: 0 RUN, 1 HALT, 2 STOP |
| wdt_kick | input | 1 | Watchdog enable/reload strobe |
| wdt_halt_en | input | 1 | Strobe allowing the watchdog to count in HALT |
| wdt_perm_set | input | 1 | Strobe selecting the permanent watchdog option |
| core_rst | output | 1 | Reset request holding the core |
| rst_cause | output | 3 | Cause of the latest reset |
| port_dflt | output | 1 | Port-mode registers return to defaults |

## Verification
The bench measures the exact length of the reset pulse, both for a single trigger and for a second trigger arriving mid-delay. A design that failed to restart the delay would show a pulse too short by the offset between the two triggers. It also times watchdog expiry to the cycle after a kick and after a reload. This catches an off-by-one terminal count, or a kick that fails to clear the counter.

The mode gating has its own tests, each run for several timeout periods:
- stop freezes the count, and a halt without permission freezes it too;
- halt permission lapses after a reset;
- a kick that lands during reset is ignored.

A design that got any of these wrong would raise an unexpected reset. The wake-pin test separates the two stop-recovery sources through `port_dflt`. The permanent-option test checks that the option survives its own watchdog reset.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_STOP = 2'd2
  } cpu_mode_e;

  typedef enum logic [2:0] {
    CAUSE_PWR     = 3'd0,
    CAUSE_WAKE    = 3'd1,
    CAUSE_WD_RUN  = 3'd2,
    CAUSE_WD_HALT = 3'd3,
    CAUSE_WD_STOP = 3'd4
  } rst_cause_e;
endpackage

// File: rtl/wrc_sync.sv
// Multi-bit bundle of independent N-flop synchronizers.
module wrc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wrc_oneshot.sv
// Restartable reset-delay one-shot: active for DLY cycles after the last trigger.
module wrc_oneshot #(
  parameter int DLY = 64,
  parameter int DCW = (DLY > 1) ? $clog2(DLY) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trig,
  output logic           active,
  output logic [DCW-1:0] cnt
);
  localparam logic [DCW-1:0] LAST = DCW'(DLY - 1);

  logic           active_n;
  logic [DCW-1:0] cnt_n;

  always_comb begin
    active_n = active;
    cnt_n    = cnt;
    if (trig) begin
      active_n = 1'b1;
      cnt_n    = '0;
    end else if (active) begin
      if (cnt == LAST) begin
        active_n = 1'b0;
        cnt_n    = '0;
      end else begin
        cnt_n = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b1;
      cnt    <= '0;
    end else begin
      active <= active_n;
      cnt    <= cnt_n;
    end
  end
endmodule

// File: rtl/wrc_wdog.sv
// Retriggerable watchdog with mode gating and a sticky permanent option.
module wrc_wdog
  import wrc_pkg::*;
#(
  parameter int TMO = 1024,
  parameter int CW  = (TMO > 1) ? $clog2(TMO) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [1:0]    mode,
  input  logic          kick,
  input  logic          halt_stb,
  input  logic          perm_stb,
  output logic          fire,
  output logic [CW-1:0] cnt,
  output logic          perm
);
  localparam logic [CW-1:0] LAST = CW'(TMO - 1);

  logic          en, halt_ok;
  logic          en_n, halt_ok_n, perm_n;
  logic [CW-1:0] cnt_n;
  logic          kick_ok, mode_ok, cnt_ok;

  always_comb begin
    kick_ok = kick & ~hold;
    mode_ok = perm | (en & ((mode == MODE_RUN) | ((mode == MODE_HALT) & halt_ok)));
    cnt_ok  = ~hold & mode_ok;
    fire    = cnt_ok & ~kick_ok & (cnt == LAST);

    cnt_n = cnt;
    if (hold)         cnt_n = '0;
    else if (kick_ok) cnt_n = '0;
    else if (cnt_ok)  cnt_n = fire ? '0 : cnt + 1'b1;

    en_n      = hold ? 1'b0 : (en | kick_ok);
    halt_ok_n = hold ? 1'b0 : (halt_ok | halt_stb);
    perm_n    = perm | perm_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      en      <= 1'b0;
      halt_ok <= 1'b0;
      perm    <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      en      <= en_n;
      halt_ok <= halt_ok_n;
      perm    <= perm_n;
    end
  end
endmodule

// File: rtl/wdt_rst_ctrl.sv
// Top: input synchronization, trigger arbitration, cause and port-default tracking.
module wdt_rst_ctrl
  import wrc_pkg::*;
#(
  parameter int DLY = 64,
  parameter int TMO = 1024
) (
  input  logic       osc_clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       wake_pin,
  input  logic       wake_alt,
  input  logic [1:0] cpu_mode,
  input  logic       wdt_kick,
  input  logic       wdt_halt_en,
  input  logic       wdt_perm_set,
  output logic       core_rst,
  output logic [2:0] rst_cause,
  output logic       port_dflt
);
  localparam int DCW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam int WCW = (TMO > 1) ? $clog2(TMO) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  // asynchronous inputs into the oscillator domain
  logic [2:0] async_s;
  wrc_sync #(.W(3), .STAGES(2)) u_sync (
    .clk   (osc_clk),
    .rst_n (rst_ns),
    .d     ({wake_alt, wake_pin, pwr_good}),
    .q     (async_s)
  );

  logic [2:0] async_d;
  always_ff @(posedge osc_clk or negedge rst_ns) begin
    if (!rst_ns) async_d <= 3'b000;
    else         async_d <= async_s;
  end

  logic pg_rise, wp_rise, wa_rise, in_stop, wake_ev;
  always_comb begin
    pg_rise = async_s[0] & ~async_d[0];
    wp_rise = async_s[1] & ~async_d[1];
    wa_rise = async_s[2] & ~async_d[2];
    in_stop = (cpu_mode == MODE_STOP);
    wake_ev = in_stop & (wp_rise | wa_rise);
  end

  // watchdog
  logic           wd_fire, wd_perm;
  logic [WCW-1:0] wd_cnt;
  wrc_wdog #(.TMO(TMO), .CW(WCW)) u_wdog (
    .clk      (osc_clk),
    .rst_n    (rst_ns),
    .hold     (core_rst),
    .mode     (cpu_mode),
    .kick     (wdt_kick),
    .halt_stb (wdt_halt_en),
    .perm_stb (wdt_perm_set),
    .fire     (wd_fire),
    .cnt      (wd_cnt),
    .perm     (wd_perm)
  );

  // trigger arbitration: power > stop recovery > watchdog
  logic       trig;
  logic [2:0] cause_n;
  logic       keep_n;
  logic [2:0] cause_q;
  logic       keep_q;

  always_comb begin
    trig    = pg_rise | wake_ev | wd_fire;
    cause_n = cause_q;
    keep_n  = keep_q;
    if (pg_rise) begin
      cause_n = CAUSE_PWR;
      keep_n  = 1'b0;
    end else if (wake_ev) begin
      cause_n = CAUSE_WAKE;
      keep_n  = wp_rise;
    end else if (wd_fire) begin
      keep_n = 1'b0;
      case (cpu_mode)
        MODE_HALT: cause_n = CAUSE_WD_HALT;
        MODE_STOP: cause_n = CAUSE_WD_STOP;
        default:   cause_n = CAUSE_WD_RUN;
      endcase
    end
  end

  always_ff @(posedge osc_clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cause_q <= CAUSE_PWR;
      keep_q  <= 1'b0;
    end else if (trig) begin
      cause_q <= cause_n;
      keep_q  <= keep_n;
    end
  end

  // reset-delay one-shot
  logic           dly_act;
  logic [DCW-1:0] dly_cnt;
  wrc_oneshot #(.DLY(DLY), .DCW(DCW)) u_dly (
    .clk    (osc_clk),
    .rst_n  (rst_ns),
    .trig   (trig),
    .active (dly_act),
    .cnt    (dly_cnt)
  );

  assign core_rst  = dly_act;
  assign rst_cause = cause_q;
  assign port_dflt = dly_act & ~keep_q;
endmodule

// File: rtl/wdt_rst_chk.sv
module wdt_rst_chk #(
  parameter int TMO = 1024,
  parameter int CW  = 10,
  parameter int DCW = 6
) (
  input logic           osc_clk,
  input logic           rst_ns,
  input logic           core_rst,
  input logic [2:0]     rst_cause,
  input logic           port_dflt,
  input logic [1:0]     cpu_mode,
  input logic           wdt_kick,
  input logic [CW-1:0]  wd_cnt,
  input logic           wd_perm,
  input logic           wd_fire,
  input logic           trig,
  input logic [DCW-1:0] dly_cnt
);
  AST_CAUSE_RANGE: assert property (@(posedge osc_clk) disable iff (!rst_ns)
    rst_cause <= 3'd4);  // R1
  AST_TRIG_RESTART: assert property (@(posedge osc_clk) disable iff (!rst_ns)
    trig |=> (core_rst && dly_cnt == '0));  // R3
  AST_PORT_DFLT: assert property (@(posedge osc_clk) disable iff (!rst_ns)
    (core_rst && rst_cause != 3'd1) |-> port_dflt);  // R5
  AST_FIRE_RST: assert property (@(posedge osc_clk) disable iff (!rst_ns)
    wd_fire |=> core_rst);  // R7
  AST_CNT_BOUND: assert property (@(posedge osc_clk) disable iff (!rst_ns)
    wd_cnt <= CW'(TMO - 1));  // R7
  AST_STOP_FREEZE: assert property (@(posedge osc_clk) disable iff (!rst_ns)
    (!wd_perm && cpu_mode == 2'd2 && !core_rst && !wdt_kick) |=> $stable(wd_cnt));  // R8
  AST_PERM_STICKY: assert property (@(posedge osc_clk) disable iff (!rst_ns)
    wd_perm |=> wd_perm);  // R9
  AST_HOLD_CLEAR: assert property (@(posedge osc_clk) disable iff (!rst_ns)
    core_rst |=> (wd_cnt == '0));  // R10
endmodule

bind wdt_rst_ctrl wdt_rst_chk #(.TMO(TMO), .CW(WCW), .DCW(DCW)) u_chk (
  .osc_clk   (osc_clk),
  .rst_ns    (rst_ns),
  .core_rst  (core_rst),
  .rst_cause (rst_cause),
  .port_dflt (port_dflt),
  .cpu_mode  (cpu_mode),
  .wdt_kick  (wdt_kick),
  .wd_cnt    (wd_cnt),
  .wd_perm   (wd_perm),
  .wd_fire   (wd_fire),
  .trig      (trig),
  .dly_cnt   (dly_cnt)
);

// File: tb/wdt_rst_ctrl_tb.sv
module wdt_rst_ctrl_tb;
  localparam int DLY = 8;
  localparam int TMO = 32;

  logic       clk = 1'b0;
  logic       rst_n, pwr_good, wake_pin, wake_alt;
  logic [1:0] cpu_mode;
  logic       wdt_kick, wdt_halt_en, wdt_perm_set;
  logic       core_rst, port_dflt;
  logic [2:0] rst_cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wdt_rst_ctrl #(.DLY(DLY), .TMO(TMO)) u_dut (
    .osc_clk      (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .wake_pin     (wake_pin),
    .wake_alt     (wake_alt),
    .cpu_mode     (cpu_mode),
    .wdt_kick     (wdt_kick),
    .wdt_halt_en  (wdt_halt_en),
    .wdt_perm_set (wdt_perm_set),
    .core_rst     (core_rst),
    .rst_cause    (rst_cause),
    .port_dflt    (port_dflt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycles (negedges) from now until core_rst is seen high; cap if never
  task automatic cycles_to_rst(input int cap, output int n);
    n = 0;
    while (!core_rst && n < cap) begin
      @(negedge clk);
      n++;
    end
  endtask

  // number of negedges on which core_rst is high, starting now
  task automatic rst_len(output int n);
    n = 0;
    while (core_rst && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (core_rst && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwr_good = 1'b1; wake_pin = 1'b0; wake_alt = 1'b0;
    cpu_mode = 2'd0; wdt_kick = 1'b0; wdt_halt_en = 1'b0; wdt_perm_set = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset core_rst", core_rst, 1);
    chk("R2 reset cause", rst_cause, 0);
    chk("R2 reset port_dflt", port_dflt, 1);
    rst_n = 1'b1;
    wait_idle();
  endtask

  task automatic t_power();
    int n;
    @(negedge clk) pwr_good = 1'b0;
    repeat (4) @(negedge clk);
    pwr_good = 1'b1;
    cycles_to_rst(20, n);
    chk("R1 power edge latency", n, 3);
    chk("R1 cause power", rst_cause, 0);
    rst_len(n);
    chk("R2 delay length", n, DLY);
  endtask

  task automatic t_retrigger();
    int n;
    cpu_mode = 2'd2;
    @(negedge clk) wake_alt = 1'b1;             // negedge A
    @(negedge clk) pwr_good = 1'b0;             // A+1
    @(negedge clk);                             // A+2
    @(negedge clk) begin pwr_good = 1'b1; wake_alt = 1'b0; end  // A+3
    chk("R3 reset started by wake", core_rst, 1);
    rst_len(n);
    chk("R3 restarted length", n, DLY + 3);
    chk("R3 cause updated to power", rst_cause, 0);
    cpu_mode = 2'd0;
  endtask

  task automatic t_wake();
    int n;
    cpu_mode = 2'd0;
    pulse(wake_pin);
    cycles_to_rst(12, n);
    chk("R4 wake ignored in RUN", core_rst, 0);
    cpu_mode = 2'd1;
    pulse(wake_alt);
    cycles_to_rst(12, n);
    chk("R4 wake ignored in HALT", core_rst, 0);
    cpu_mode = 2'd2;
    pulse(wake_pin);
    cycles_to_rst(12, n);
    chk("R4 wake pin in STOP resets", core_rst, 1);
    chk("R4 cause stop recovery", rst_cause, 1);
    chk("R5 pin wake keeps ports", port_dflt, 0);
    wait_idle();
    pulse(wake_alt);
    cycles_to_rst(12, n);
    chk("R4 alt wake cause", rst_cause, 1);
    chk("R5 alt wake restores ports", port_dflt, 1);
    wait_idle();
    cpu_mode = 2'd0;
  endtask

  task automatic t_disabled();
    int n;
    cpu_mode = 2'd0;
    cycles_to_rst(3 * TMO, n);
    chk("R6 no timeout before first kick", core_rst, 0);
  endtask

  task automatic t_run_timeout();
    int n;
    pulse(wdt_kick);
    repeat (TMO - 4) @(negedge clk);
    chk("R7 no early timeout", core_rst, 0);
    pulse(wdt_kick);
    cycles_to_rst(3 * TMO, n);
    chk("R7 timeout after reload", n, TMO);
    chk("R7 cause RUN watchdog", rst_cause, 2);
    chk("R7 watchdog reset restores ports", port_dflt, 1);
    wait_idle();
  endtask

  task automatic t_kick_in_reset();
    int n;
    cpu_mode = 2'd2;
    pulse(wake_alt);
    cycles_to_rst(12, n);
    @(negedge clk) wdt_kick = 1'b1;
    @(negedge clk) wdt_kick = 1'b0;
    cpu_mode = 2'd0;
    wait_idle();
    cycles_to_rst(3 * TMO, n);
    chk("R10 kick during reset ignored", core_rst, 0);
  endtask

  task automatic t_modes();
    int n;
    pulse(wdt_kick);
    cpu_mode = 2'd2;
    cycles_to_rst(3 * TMO, n);
    chk("R8 frozen in STOP", core_rst, 0);
    cpu_mode = 2'd1;
    cycles_to_rst(3 * TMO, n);
    chk("R8 frozen in HALT without permission", core_rst, 0);
    pulse(wdt_halt_en);
    pulse(wdt_kick);
    cycles_to_rst(3 * TMO, n);
    chk("R8 HALT timeout", n, TMO);
    chk("R8 cause HALT watchdog", rst_cause, 3);
    wait_idle();
    cpu_mode = 2'd0;
    pulse(wdt_kick);
    cpu_mode = 2'd1;
    cycles_to_rst(3 * TMO, n);
    chk("R8 halt permission cleared by reset", core_rst, 0);
    cpu_mode = 2'd0;
    pulse(wdt_kick);
    cycles_to_rst(3 * TMO, n);
    wait_idle();
  endtask

  task automatic t_perm();
    int n;
    cpu_mode = 2'd2;
    pulse(wdt_perm_set);
    cycles_to_rst(3 * TMO, n);
    chk("R9 permanent counts in STOP", n, TMO);
    chk("R9 cause STOP watchdog", rst_cause, 4);
    cpu_mode = 2'd0;
    wait_idle();
    cycles_to_rst(3 * TMO, n);
    chk("R9 still armed after own reset", n, TMO);
    chk("R9 cause RUN watchdog", rst_cause, 2);
    wait_idle();
  endtask

  initial begin
    t_reset();
    t_power();
    t_retrigger();
    t_wake();
    t_disabled();
    t_run_timeout();
    t_kick_in_reset();
    t_modes();
    t_perm();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule